// File: doc/BRIEF.md
# PHY Link Setup Sequencer

This block brings an attached Ethernet PHY into a known operating mode after a start pulse. It drives a simple request/response port towards an MDIO master, one transaction at a time. Through that port it waits for any reset in progress to finish and then soft-resets the PHY. If autonegotiation is switched off it forces 10 Mbit half duplex. Otherwise it waits for autonegotiation to complete and picks the best mode that both link ends can run.

Gigabit modes are tried first, using the 1000BASE-T control and status pair. They apply only when the PHY reports extended status and the MAC says it can run gigabit. Otherwise the 10/100 advertisement and link-partner words decide the mode. A millisecond timeout bounds every wait. If autonegotiation stalls, the mode is decoded from the forced speed and duplex bits of the control register. If the PHY never leaves reset, the block ends with a timeout and the lowest mode.

Top module: `phy_link_seq`

## Requirements
- R1: After `start`, register 0 is read until its bit 15 reads 0. Register 0 is then written with that last read value OR 0x8000, and read again until bit 15 reads 0.
- R2: If bit 12 of the last register 0 value is 0, register 0 is written with 0x0000. The block then finishes with all three mode flags at 0 and `timeout` at 0.
- R3: If bit 12 is 1, register 1 is read until bit 5 reads 1. Only then are the ability registers read.
- R4: If register 1 bit 8 is 1, registers 9 and 10 are read. Gigabit full duplex is chosen when reg9[9] and reg10[11] are both 1. Otherwise gigabit half duplex is chosen when reg9[8] and reg10[10] are both 1. The gigabit choice is used only when `gbit_capable` is 1, giving `link_gbit`=1 and `link_100`=0.
- R5: Without a usable gigabit choice, registers 4 and 5 are ANDed. Bit 8 of the result gives 100 full, bit 7 gives 100 half, bit 6 gives 10 full, and no match gives 10 half, in that priority.
- R6: When a gigabit choice exists but `gbit_capable` is 0, the R5 result is used. Register 0 is then written with `link_100` in bit 13 and all other bits 0.
- R7: If bit 5 of register 1 has not been seen by the time the timeout expires, register 0 is read and decoded. `link_gbit` = bit6 & !bit13, `link_100` = !bit6 & bit13, `link_full` = bit8. `timeout` is set to 1.
- R8: If the timeout expires while register 0 bit 15 is still 1, the block finishes with `done`=1, `timeout`=1 and all mode flags 0.
- R9: `done` rises once per run. `done`, `timeout` and the mode flags then hold until the next `start`, which clears `done` and `timeout` in the following cycle. No request is issued while `done` is 1.
- R10: `req_valid` is a one-cycle pulse. No new request is issued until `rsp_valid` has returned for the previous one.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a setup run |
| gbit_capable | input | 1 | MAC can run at 1000 Mbit |
| req_valid | output | 1 | MDIO transaction request pulse |
| req_write | output | 1 | 1 = write, 0 = read |
| req_reg | output | 5 | PHY register address |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Transaction finished |
| rsp_rdata | input | 16 | Read data, valid with rsp_valid |
| link_gbit | output | 1 | 1000 Mbit selected |
| link_100 | output | 1 | 100 Mbit selected |
| link_full | output | 1 | Full duplex selected |
| done | output | 1 | Setup finished |
| timeout | output | 1 | Setup ended by the timeout |

## Verification
The bench builds the block with two cycles per millisecond and a 40 ms limit, so the whole timeout window is 80 cycles. This makes both timeout paths reachable in a short run: a PHY that never leaves reset, and autonegotiation that never completes. With only a few polls, normal runs still finish well inside the window. The limit also exercises the forced-bit decode on random control words. The behavioural PHY answers every request after a fixed latency, so the one-outstanding rule is tested against real gaps.

// File: rtl/phy_link_pkg.sv
package phy_link_pkg;
  localparam int DW = 16;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_CTRL = 5'd0;
  localparam logic [AW-1:0] A_STAT = 5'd1;
  localparam logic [AW-1:0] A_FADV = 5'd4;
  localparam logic [AW-1:0] A_FPRT = 5'd5;
  localparam logic [AW-1:0] A_GADV = 5'd9;
  localparam logic [AW-1:0] A_GPRT = 5'd10;

  localparam int B_RESET   = 15;
  localparam int B_SPD_LO  = 13;
  localparam int B_ANEN    = 12;
  localparam int B_DUPLEX  = 8;
  localparam int B_SPD_HI  = 6;
  localparam int B_ANDONE  = 5;
  localparam int B_EXTST   = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_RST_WR, S_POST, S_FORCE_WR, S_AN,
    S_GB_ADV, S_GB_PRT, S_GB_EVAL, S_FE_ADV, S_FE_PRT,
    S_FE_EVAL, S_SPD_WR, S_TO_RD, S_DONE
  } step_t;

  typedef struct packed {
    logic gbit;
    logic m100;
    logic full;
  } mode_t;

  function automatic mode_t decode_forced(input logic [DW-1:0] c);
    mode_t m;
    m.gbit = c[B_SPD_HI] & ~c[B_SPD_LO];
    m.m100 = ~c[B_SPD_HI] & c[B_SPD_LO];
    m.full = c[B_DUPLEX];
    return m;
  endfunction
endpackage

// File: rtl/phy_link_timer.sv
module phy_link_timer #(
  parameter int CYCLES_PER_MS = 100000,
  parameter int TIMEOUT_MS    = 3000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic expired
);
  localparam int SW = $clog2(CYCLES_PER_MS + 1);
  localparam int MW = $clog2(TIMEOUT_MS + 1);

  logic [SW-1:0] sub_q;
  logic [MW-1:0] ms_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sub_q   <= '0;
      ms_q    <= '0;
      expired <= 1'b0;
    end else if (!expired) begin
      if (sub_q == SW'(CYCLES_PER_MS - 1)) begin
        sub_q <= '0;
        ms_q  <= ms_q + 1'b1;
        if (ms_q == MW'(TIMEOUT_MS - 1)) expired <= 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/phy_link_resolve.sv
module phy_link_resolve
  import phy_link_pkg::*;
(
  input  logic [DW-1:0] gadv,
  input  logic [DW-1:0] gprt,
  input  logic [DW-1:0] fadv,
  input  logic [DW-1:0] fprt,
  output logic          gb_hit,
  output logic          gb_full,
  output logic          fe_100,
  output logic          fe_full
);
  logic g_fd, g_hd;
  logic [DW-1:0] common;

  always_comb begin
    g_fd    = gadv[9] & gprt[11];
    g_hd    = gadv[8] & gprt[10];
    gb_hit  = g_fd | g_hd;
    gb_full = g_fd;
    common  = fadv & fprt;
    if (common[8]) begin
      fe_100 = 1'b1; fe_full = 1'b1;
    end else if (common[7]) begin
      fe_100 = 1'b1; fe_full = 1'b0;
    end else if (common[6]) begin
      fe_100 = 1'b0; fe_full = 1'b1;
    end else begin
      fe_100 = 1'b0; fe_full = 1'b0;
    end
  end
endmodule

// File: rtl/phy_link_seq.sv
module phy_link_seq
  import phy_link_pkg::*;
#(
  parameter int CYCLES_PER_MS = 100000,
  parameter int TIMEOUT_MS    = 3000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          gbit_capable,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_reg,
  output logic [DW-1:0] req_wdata,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output logic          link_gbit,
  output logic          link_100,
  output logic          link_full,
  output logic          done,
  output logic          timeout
);
  step_t          state;
  logic           pending;
  logic [DW-1:0]  ctrl_q, gadv_q, gprt_q, fadv_q, fprt_q;
  logic           expired;
  logic           gb_hit, gb_full, fe_100, fe_full;
  logic           xact, wr;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  wdata;
  mode_t          forced;

  phy_link_timer #(.CYCLES_PER_MS(CYCLES_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
    .clk(clk), .rst(rst), .clear(start), .expired(expired)
  );

  phy_link_resolve u_res (
    .gadv(gadv_q), .gprt(gprt_q), .fadv(fadv_q), .fprt(fprt_q),
    .gb_hit(gb_hit), .gb_full(gb_full), .fe_100(fe_100), .fe_full(fe_full)
  );

  always_comb begin
    xact  = 1'b1;
    wr    = 1'b0;
    addr  = A_CTRL;
    wdata = '0;
    case (state)
      S_PRE, S_POST, S_TO_RD: addr = A_CTRL;
      S_RST_WR:   begin wr = 1'b1; wdata = ctrl_q | (DW'(1) << B_RESET); end
      S_FORCE_WR: wr = 1'b1;
      S_SPD_WR:   begin wr = 1'b1; wdata = DW'(link_100) << B_SPD_LO; end
      S_AN:       addr = A_STAT;
      S_GB_ADV:   addr = A_GADV;
      S_GB_PRT:   addr = A_GPRT;
      S_FE_ADV:   addr = A_FADV;
      S_FE_PRT:   addr = A_FPRT;
      default:    xact = 1'b0;
    endcase
    forced = decode_forced(rsp_rdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pending   <= 1'b0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_reg   <= '0;
      req_wdata <= '0;
      ctrl_q    <= '0;
      gadv_q    <= '0;
      gprt_q    <= '0;
      fadv_q    <= '0;
      fprt_q    <= '0;
      link_gbit <= 1'b0;
      link_100  <= 1'b0;
      link_full <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      if (start) begin
        state   <= S_PRE;
        pending <= 1'b0;
        done    <= 1'b0;
        timeout <= 1'b0;
        gadv_q  <= '0;
        gprt_q  <= '0;
        fadv_q  <= '0;
        fprt_q  <= '0;
        {link_gbit, link_100, link_full} <= 3'b000;
      end else if (xact && !pending) begin
        req_valid <= 1'b1;
        req_write <= wr;
        req_reg   <= addr;
        req_wdata <= wdata;
        pending   <= 1'b1;
      end else if (xact && rsp_valid) begin
        pending <= 1'b0;
        case (state)
          S_PRE, S_POST: begin
            ctrl_q <= rsp_rdata;
            if (rsp_rdata[B_RESET]) begin
              if (expired) begin
                state <= S_DONE; done <= 1'b1; timeout <= 1'b1;
              end
            end else if (state == S_PRE) begin
              state <= S_RST_WR;
            end else begin
              state <= rsp_rdata[B_ANEN] ? S_AN : S_FORCE_WR;
            end
          end
          S_RST_WR: state <= S_POST;
          S_FORCE_WR, S_SPD_WR: begin
            state <= S_DONE; done <= 1'b1;
          end
          S_AN: begin
            if (rsp_rdata[B_ANDONE])
              state <= rsp_rdata[B_EXTST] ? S_GB_ADV : S_FE_ADV;
            else if (expired) begin
              state <= S_TO_RD; timeout <= 1'b1;
            end
          end
          S_GB_ADV: begin gadv_q <= rsp_rdata; state <= S_GB_PRT; end
          S_GB_PRT: begin gprt_q <= rsp_rdata; state <= S_GB_EVAL; end
          S_FE_ADV: begin fadv_q <= rsp_rdata; state <= S_FE_PRT; end
          S_FE_PRT: begin fprt_q <= rsp_rdata; state <= S_FE_EVAL; end
          S_TO_RD: begin
            {link_gbit, link_100, link_full} <= forced;
            state <= S_DONE; done <= 1'b1;
          end
          default: state <= S_DONE;
        endcase
      end else if (state == S_GB_EVAL) begin
        if (gb_hit && gbit_capable) begin
          {link_gbit, link_100, link_full} <= {1'b1, 1'b0, gb_full};
          state <= S_DONE; done <= 1'b1;
        end else begin
          state <= S_FE_ADV;
        end
      end else if (state == S_FE_EVAL) begin
        {link_gbit, link_100, link_full} <= {1'b0, fe_100, fe_full};
        if (gb_hit && !gbit_capable) state <= S_SPD_WR;
        else begin
          state <= S_DONE; done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk
  import phy_link_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          req_valid,
  input logic          rsp_valid,
  input logic          link_gbit,
  input logic          link_100,
  input logic          link_full,
  input logic          done,
  input logic          timeout
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (rst || start) outstanding <= 1'b0;
    else if (req_valid) outstanding <= 1'b1;
    else if (rsp_valid) outstanding <= 1'b0;
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    outstanding |-> !req_valid); // R10
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R9
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable({link_gbit, link_100, link_full, timeout})); // R9
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_valid); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && !timeout)); // R9
  AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (rst)
    (timeout && !start) |=> (done || timeout)); // R7
  AST_SPEED_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(link_gbit && link_100)); // R4
endmodule

bind phy_link_seq phy_link_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .link_gbit(link_gbit), .link_100(link_100),
  .link_full(link_full), .done(done), .timeout(timeout)
);

// File: tb/phy_link_seq_test.sv
module phy_link_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPM = 2;
  localparam int TMS = 40;
  localparam int LAT = 2;

  logic clk = 0, rst = 1, start = 0, gbit_capable = 0;
  logic req_valid, req_write;
  logic [4:0] req_reg;
  logic [15:0] req_wdata;
  logic rsp_valid = 0;
  logic [15:0] rsp_rdata = 0;
  logic link_gbit, link_100, link_full, done, timeout;

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [15:0] preg [32];
  int rst_left, an_left;
  bit rst_never, an_never;
  logic [15:0] rst_wr_data, last_wr_data;
  logic [4:0] last_wr_reg;
  int wr_count;

  phy_link_seq #(.CYCLES_PER_MS(CPM), .TIMEOUT_MS(TMS)) uut (
    .clk(clk), .rst(rst), .start(start), .gbit_capable(gbit_capable),
    .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .link_gbit(link_gbit), .link_100(link_100), .link_full(link_full),
    .done(done), .timeout(timeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural PHY behind the MDIO master
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (req_valid) begin
        logic w; logic [4:0] a; logic [15:0] d, r;
        w = req_write; a = req_reg; d = req_wdata; r = 0;
        if (w) begin
          wr_count++; last_wr_reg = a; last_wr_data = d;
          if (a == 0 && d[15]) begin
            rst_wr_data = d; preg[0] = d & 16'h7fff; rst_left = 2;
          end else preg[a] = d;
        end else begin
          r = preg[a];
          if (a == 0 && (rst_never || rst_left > 0)) begin
            r[15] = 1; if (rst_left > 0) rst_left--;
          end
          if (a == 1) begin
            r[5] = 0;
            if (!an_never) begin
              if (an_left > 0) an_left--; else r[5] = 1;
            end
          end
        end
        repeat (LAT) @(negedge clk);
        rsp_rdata = r; rsp_valid = 1;
      end
    end
  end

  function automatic logic [3:0] exp_mode(input logic [15:0] r1, r9, r10, r4, r5, input logic cap);
    logic gb, gfd, sp, fd, spdwr; logic [15:0] c;
    gb = 0; gfd = 0; spdwr = 0;
    if (r1[8]) begin
      if (r9[9] && r10[11]) begin gb = 1; gfd = 1; end
      else if (r9[8] && r10[10]) gb = 1;
    end
    if (gb && cap) return {1'b1, 1'b0, gfd, 1'b0};
    c = r4 & r5;
    if (c[8]) begin sp = 1; fd = 1; end
    else if (c[7]) begin sp = 1; fd = 0; end
    else if (c[6]) begin sp = 0; fd = 1; end
    else begin sp = 0; fd = 0; end
    spdwr = gb;
    return {1'b0, sp, fd, spdwr};
  endfunction

  task automatic setup(input logic [15:0] r0, r1, r4, r5, r9, r10, input logic cap,
                       input bit rnever, input bit anever);
    for (int i = 0; i < 32; i++) preg[i] = 16'h0;
    preg[0] = r0; preg[1] = r1; preg[4] = r4; preg[5] = r5; preg[9] = r9; preg[10] = r10;
    rst_left = 1; an_left = 2; rst_never = rnever; an_never = anever;
    wr_count = 0; rst_wr_data = 16'hdead; last_wr_data = 16'hdead; last_wr_reg = 5'h1f;
    gbit_capable = cap;
  endtask

  task automatic run_wait(input string req);
    int n;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk({req, " start clears done R9"}, {31'd0, done}, 32'd0);
    n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    chk({req, " done reached"}, {31'd0, done}, 32'd1);
  endtask

  task automatic run_normal(input string req, input logic [15:0] r0, r1, r4, r5, r9, r10, input logic cap);
    logic [3:0] e;
    setup(r0, r1, r4, r5, r9, r10, cap, 0, 0);
    e = exp_mode(r1, r9, r10, r4, r5, cap);
    run_wait(req);
    chk({req, " mode"}, {29'd0, link_gbit, link_100, link_full}, {29'd0, e[3:1]});
    chk({req, " no timeout"}, {31'd0, timeout}, 32'd0);
    chk({req, " reset write R1"}, {16'd0, rst_wr_data}, {16'd0, r0 | 16'h8000});
    if (e[0]) chk({req, " speed write R6"}, {11'd0, last_wr_reg, last_wr_data},
                  {11'd0, 5'd0, 2'b00, e[2], 13'd0});
    else chk({req, " write count R3"}, wr_count, 1);
  endtask

  initial begin
    int n = 0;
    while (!finished && n < 150000) begin @(posedge clk); n++; end
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] r0;
    void'($urandom(32'd1234));
    setup(16'h1000, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset outputs", {26'd0, req_valid, link_gbit, link_100, link_full, done, timeout}, 32'd0);

    // R2 autonegotiation disabled
    setup(16'h0140, 0, 0, 0, 0, 0, 1, 0, 0);
    run_wait("R2");
    chk("R2 mode 10 half", {29'd0, link_gbit, link_100, link_full}, 32'd0);
    chk("R2 forced write", {11'd0, last_wr_reg, last_wr_data}, 32'd0);
    chk("R2 no timeout", {31'd0, timeout}, 32'd0);
    chk("R1 reset write", {16'd0, rst_wr_data}, 32'h8140);

    // R4 directed gigabit cases
    run_normal("R4 gig full", 16'h1140, 16'h0100, 16'h01e0, 16'h01e0, 16'h0300, 16'h0c00, 1);
    run_normal("R4 gig half", 16'h1000, 16'h0100, 16'h01e0, 16'h01e0, 16'h0100, 16'h0c00, 1);
    // R6 gig possible but MAC not capable
    run_normal("R6 gig no mac", 16'h1000, 16'h0100, 16'h0080, 16'h0180, 16'h0300, 16'h0c00, 0);
    // R5 no extended status
    run_normal("R5 10 full", 16'h1000, 16'h0000, 16'h0040, 16'h00c0, 16'h0300, 16'h0c00, 1);
    run_normal("R5 10 half", 16'h1000, 16'h0000, 16'h0020, 16'h0020, 16'h0000, 16'h0000, 1);

    // R9 stability after done
    repeat (20) @(negedge clk);
    chk("R9 done held", {31'd0, done}, 32'd1);
    chk("R9 mode held", {29'd0, link_gbit, link_100, link_full}, 32'd0);

    // R8 PHY stuck in reset
    setup(16'h1140, 0, 0, 0, 0, 0, 1, 1, 0);
    run_wait("R8");
    chk("R8 timeout", {31'd0, timeout}, 32'd1);
    chk("R8 mode zero", {29'd0, link_gbit, link_100, link_full}, 32'd0);
    chk("R8 no reset write", wr_count, 0);

    // R7 autonegotiation never finishes, random forced bits
    for (int k = 0; k < 6; k++) begin
      r0 = 16'h1000 | (16'($urandom) & 16'h2140);
      setup(r0, 16'h0100, 16'h01e0, 16'h01e0, 16'h0300, 16'h0c00, 1, 0, 1);
      run_wait("R7");
      chk("R7 timeout", {31'd0, timeout}, 32'd1);
      chk("R7 forced decode", {29'd0, link_gbit, link_100, link_full},
          {29'd0, r0[6] & ~r0[13], ~r0[6] & r0[13], r0[8]});
    end

    // random ability mixes (R4 R5 R6)
    for (int k = 0; k < 30; k++) begin
      run_normal("R5 random", 16'h1000 | (16'($urandom) & 16'h0140),
                 16'($urandom) & 16'h0100, 16'($urandom) & 16'h01e0, 16'($urandom) & 16'h01e0,
                 16'($urandom) & 16'h0300, 16'($urandom) & 16'h0c00, 1'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule